// File: doc/BRIEF.md
# Indexed RGB palette port

A 256-entry colour lookup table shared between a host processor and a pixel pipeline. The host sees four byte-wide registers picked by a 2-bit select. One register points the write sequence at an entry. A second points the read sequence at an entry. A third holds a pixel mask. The fourth is a single data port. The data port carries colour components one at a time: red, then green, then blue. The write sequence and the read sequence each keep their own entry index and their own three-step component counter.

Each component keeps 6 bits. On the write side, red and green wait in holding registers, and the whole entry is written to the table when blue arrives. Both sequences move on to the next entry after blue and wrap from 255 to 0. The pixel side presents an 8-bit index each clock. The index is ANDed with the mask register, and the table returns the stored triple one clock later. This lookup runs at the same time as any host access.

Top module: `palette_port`

## Requirements
- R1: A write with select 0 (write-index register) loads the write entry index from the data byte and resets the write component counter to red. A read with select 0 returns the current write entry index.
- R2: Writes with select 1 (data port) are taken as red, green, then blue, tracked by a counter that counts modulo 3. The table entry changes only when the blue component is written, and it then holds all three components at once.
- R3: Writing the blue component advances the write entry index by one. Writing red or green leaves the index unchanged.
- R4: Entry indices wrap from 255 to 0. After 768 data writes that start at entry 0, a read of select 0 returns 0.
- R5: A write with select 3 (read-index register) loads the read entry index and resets the read component counter. Each read with select 1 returns the next component in the order red, green, blue, and the read index advances by one (wrapping) after blue. A read with select 3 returns the read entry index.
- R6: Only data bits 5:0 of each component are stored, and bits 7:6 of a written component are ignored. A data-port read returns the component in bits 5:0, with bits 7:6 zero.
- R7: A write with select 2 sets the mask register, and a read with select 2 returns it. The pixel index is ANDed with the mask before the lookup, so the value 0xFF leaves the index unchanged.
- R8: The pixel outputs show the entry addressed one clock earlier. If the host writes that same entry in the same cycle, the pixel outputs show the contents from before the write.
- R9: After reset the mask is 0xFF, both entry indices and both component counters are 0, and the pixel outputs are 0.
- R10: Host reads of selects 0, 2 and 3 change no state. When host_wr and host_rd are both high in one cycle, only the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 2 | Register select: 0 write index, 1 data, 2 mask, 3 read index |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (advances the data read sequence) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the selected register (combinational) |
| pix_idx | input | 8 | Pixel index from the display pipeline |
| pix_red | output | 6 | Red component of the looked-up entry |
| pix_grn | output | 6 | Green component of the looked-up entry |
| pix_blu | output | 6 | Blue component of the looked-up entry |

## Verification
The bench goes after these cases:
- It reloads the write index halfway through a triple. A design that kept the stale component counter would put later bytes in the wrong colour slots.
- It watches an entry between its green write and its blue write. A design that wrote each component straight into the table would show a half-updated colour.
- It runs both sequences across the 255-to-0 boundary and writes components with bits 7:6 set. A design that got the wrap wrong, or kept the upper bits, would give a wrong index readback or components wider than 6 bits.
- It looks up an entry with a pixel index in the same cycle the host writes that entry. It also varies the mask, and it raises both strobes together. These catch a design that reads through to new data, ignores the mask, or lets a colliding read advance the read sequence.

// File: rtl/pal_pkg.sv
package pal_pkg;

    localparam int COMP_W = 6;

    typedef enum logic [1:0] {
        SEL_WIDX = 2'd0,
        SEL_DATA = 2'd1,
        SEL_MASK = 2'd2,
        SEL_RIDX = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_e;

    typedef struct packed {
        logic [COMP_W-1:0] red;
        logic [COMP_W-1:0] grn;
        logic [COMP_W-1:0] blu;
    } rgb_t;

    function automatic phase_e next_phase(input phase_e p);
        case (p)
            PH_RED:  return PH_GRN;
            PH_GRN:  return PH_BLU;
            default: return PH_RED;
        endcase
    endfunction

    function automatic logic [COMP_W-1:0] pick_comp(input rgb_t e, input phase_e p);
        case (p)
            PH_RED:  return e.red;
            PH_GRN:  return e.grn;
            default: return e.blu;
        endcase
    endfunction

endpackage

// File: rtl/pal_seq.sv
module pal_seq
    import pal_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [IDX_W-1:0] load_val,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output phase_e           phase
);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx   <= '0;
            phase <= PH_RED;
        end else if (load) begin
            idx   <= load_val;
            phase <= PH_RED;
        end else if (step) begin
            phase <= next_phase(phase);
            if (phase == PH_BLU) begin
                idx <= idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pal_store.sv
module pal_store
    import pal_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  rgb_t             wentry,
    input  logic [IDX_W-1:0] haddr,
    output rgb_t             hentry,
    input  logic [IDX_W-1:0] paddr,
    output rgb_t             pentry
);

    localparam int DEPTH = 1 << IDX_W;

    rgb_t table_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            table_q[waddr] <= wentry;
        end
    end

    assign hentry = table_q[haddr];

    always_ff @(posedge clk) begin
        if (rst) begin
            pentry <= '0;
        end else begin
            pentry <= table_q[paddr];
        end
    end

endmodule

// File: rtl/palette_port.sv
module palette_port
    import pal_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        host_sel,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [IDX_W-1:0]  pix_idx,
    output logic [COMP_W-1:0] pix_red,
    output logic [COMP_W-1:0] pix_grn,
    output logic [COMP_W-1:0] pix_blu
);

    localparam int PAD_W = DATA_W - COMP_W;
    localparam int IPAD  = DATA_W - IDX_W;

    reg_sel_e sel;
    assign sel = reg_sel_e'(host_sel);

    logic wr_load, wr_step, rd_load, rd_step, mask_load;
    assign wr_load   = host_wr && (sel == SEL_WIDX);
    assign wr_step   = host_wr && (sel == SEL_DATA);
    assign mask_load = host_wr && (sel == SEL_MASK);
    assign rd_load   = host_wr && (sel == SEL_RIDX);
    assign rd_step   = host_rd && !host_wr && (sel == SEL_DATA);

    logic [IDX_W-1:0] wr_idx, rd_idx;
    phase_e           wr_ph, rd_ph;

    pal_seq #(.IDX_W(IDX_W)) u_wseq (
        .clk      (clk),
        .rst      (rst),
        .load     (wr_load),
        .load_val (host_wdata[IDX_W-1:0]),
        .step     (wr_step),
        .idx      (wr_idx),
        .phase    (wr_ph)
    );

    pal_seq #(.IDX_W(IDX_W)) u_rseq (
        .clk      (clk),
        .rst      (rst),
        .load     (rd_load),
        .load_val (host_wdata[IDX_W-1:0]),
        .step     (rd_step),
        .idx      (rd_idx),
        .phase    (rd_ph)
    );

    logic [COMP_W-1:0] red_hold, grn_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            red_hold <= '0;
            grn_hold <= '0;
        end else if (wr_step) begin
            if (wr_ph == PH_RED) red_hold <= host_wdata[COMP_W-1:0];
            if (wr_ph == PH_GRN) grn_hold <= host_wdata[COMP_W-1:0];
        end
    end

    logic [IDX_W-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
        end else if (mask_load) begin
            mask_q <= host_wdata[IDX_W-1:0];
        end
    end

    rgb_t new_entry, host_entry, pix_entry;
    logic commit;

    assign commit    = wr_step && (wr_ph == PH_BLU);
    assign new_entry = '{red: red_hold, grn: grn_hold, blu: host_wdata[COMP_W-1:0]};

    pal_store #(.IDX_W(IDX_W)) u_store (
        .clk    (clk),
        .rst    (rst),
        .we     (commit),
        .waddr  (wr_idx),
        .wentry (new_entry),
        .haddr  (rd_idx),
        .hentry (host_entry),
        .paddr  (pix_idx & mask_q),
        .pentry (pix_entry)
    );

    always_comb begin
        case (sel)
            SEL_WIDX: host_rdata = {{IPAD{1'b0}}, wr_idx};
            SEL_DATA: host_rdata = {{PAD_W{1'b0}}, pick_comp(host_entry, rd_ph)};
            SEL_MASK: host_rdata = {{IPAD{1'b0}}, mask_q};
            default:  host_rdata = {{IPAD{1'b0}}, rd_idx};
        endcase
    end

    assign pix_red = pix_entry.red;
    assign pix_grn = pix_entry.grn;
    assign pix_blu = pix_entry.blu;

endmodule

// File: rtl/pal_chk.sv
module pal_chk
    import pal_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        host_sel,
    input logic              host_wr,
    input logic              host_rd,
    input logic [DATA_W-1:0] host_wdata,
    input logic [DATA_W-1:0] host_rdata,
    input logic [IDX_W-1:0]  wr_idx,
    input phase_e            wr_ph,
    input logic [IDX_W-1:0]  rd_idx,
    input phase_e            rd_ph,
    input logic [IDX_W-1:0]  mask_q
);

    assert_widx_load_R1: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_sel == 2'd0) |=>
            (wr_idx == $past(host_wdata[IDX_W-1:0]) && wr_ph == PH_RED));

    assert_phase_legal_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_ph != 2'd3) && (rd_ph != 2'd3));

    assert_hold_idx_R3: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_sel == 2'd1 && wr_ph != PH_BLU) |=> $stable(wr_idx));

    // also covers the 255 -> 0 wrap (R4)
    assert_blue_advance_R3: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_sel == 2'd1 && wr_ph == PH_BLU) |=>
            (wr_idx == IDX_W'($past(wr_idx) + 1'b1) && wr_ph == PH_RED));

    assert_ridx_load_R5: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_sel == 2'd3) |=>
            (rd_idx == $past(host_wdata[IDX_W-1:0]) && rd_ph == PH_RED));

    assert_zero_ext_R6: assert property (@(posedge clk) disable iff (rst)
        (host_sel == 2'd1) |-> (host_rdata[DATA_W-1:COMP_W] == '0));

    assert_mask_load_R7: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_sel == 2'd2) |=> (mask_q == $past(host_wdata[IDX_W-1:0])));

    assert_reset_R9: assert property (@(posedge clk)
        rst |=> (wr_idx == '0 && rd_idx == '0 && wr_ph == PH_RED &&
                 rd_ph == PH_RED && mask_q == '1));

    assert_no_side_R10: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !host_wr && host_sel != 2'd1) |=> ($stable(rd_idx) && $stable(rd_ph)));

    assert_wr_priority_R10: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_wr && host_sel == 2'd1) |=> ($stable(rd_idx) && $stable(rd_ph)));

endmodule

bind palette_port pal_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_sel   (host_sel),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .wr_idx     (wr_idx),
    .wr_ph      (wr_ph),
    .rd_idx     (rd_idx),
    .rd_ph      (rd_ph),
    .mask_q     (mask_q)
);

// File: tb/tb_palette_port.sv
module tb_palette_port;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] host_sel = 2'd0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic [7:0] pix_idx = 8'd0;
    logic [5:0] pix_red, pix_grn, pix_blu;

    always #(CLK_PERIOD/2) clk = ~clk;

    palette_port dut (
        .clk        (clk),
        .rst        (rst),
        .host_sel   (host_sel),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .pix_idx    (pix_idx),
        .pix_red    (pix_red),
        .pix_grn    (pix_grn),
        .pix_blu    (pix_blu)
    );

    int n_vec  = 0;
    int n_fail = 0;

    // behavioural reference model
    int m_r [256];
    int m_g [256];
    int m_b [256];
    int widx = 0, wph = 0, ridx = 0, rph = 0, mask = 255, sr = 0, sg = 0;
    bit pix_on = 1'b0;

    task automatic check(input int act, input int exp, input string req);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int exp_rdata(input logic [1:0] s);
        case (s)
            2'd0: return widx;
            2'd1: return (rph == 0) ? m_r[ridx] : (rph == 1) ? m_g[ridx] : m_b[ridx];
            2'd2: return mask;
            default: return ridx;
        endcase
    endfunction

    task automatic step(input logic [1:0] s, input logic w, input logic r,
                        input logic [7:0] d, input logic [7:0] p, input string req);
        int pe_r, pe_g, pe_b, pa;
        @(negedge clk);
        host_sel = s; host_wr = w; host_rd = r; host_wdata = d; pix_idx = p;
        #1;
        if (r && !w) check(int'(host_rdata), exp_rdata(s), req);
        pa = int'(p) & mask;
        pe_r = m_r[pa]; pe_g = m_g[pa]; pe_b = m_b[pa];
        if (w) begin
            case (s)
                2'd0: begin widx = d; wph = 0; end
                2'd1: begin
                    if (wph == 0) sr = d & 63;
                    else if (wph == 1) sg = d & 63;
                    else begin
                        m_r[widx] = sr; m_g[widx] = sg; m_b[widx] = d & 63;
                        widx = (widx + 1) % 256;
                    end
                    wph = (wph + 1) % 3;
                end
                2'd2: mask = d;
                default: begin ridx = d; rph = 0; end
            endcase
        end else if (r && s == 2'd1) begin
            if (rph == 2) ridx = (ridx + 1) % 256;
            rph = (rph + 1) % 3;
        end
        @(posedge clk);
        #1;
        if (pix_on) begin
            // R8: one-cycle lookup, old contents on a same-cycle write
            check(int'(pix_red), pe_r, "R7/R8 pix_red");
            check(int'(pix_grn), pe_g, "R7/R8 pix_grn");
            check(int'(pix_blu), pe_b, "R7/R8 pix_blu");
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d, input logic [7:0] p, input string req);
        step(s, 1'b1, 1'b0, d, p, req);
    endtask

    task automatic rd(input logic [1:0] s, input logic [7:0] p, input string req);
        step(s, 1'b0, 1'b1, 8'd0, p, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin m_r[i] = 0; m_g[i] = 0; m_b[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        check(int'(pix_red), 0, "R9 pix_red");
        check(int'(pix_blu), 0, "R9 pix_blu");
        rd(2'd0, 8'd0, "R9 write index");
        rd(2'd3, 8'd0, "R9 read index");
        rd(2'd2, 8'd0, "R9 mask");

        // R4/R6: fill whole table from entry 0, upper bits set on every component
        wr(2'd0, 8'd0, 8'd0, "R1");
        for (int i = 0; i < 256; i++) begin
            wr(2'd1, 8'(i * 5 + 1) | 8'hC0, 8'd0, "R2");
            wr(2'd1, 8'(i * 3 + 7) | 8'h80, 8'd0, "R2");
            wr(2'd1, 8'(i * 7 + 2) | 8'h40, 8'd0, "R2");
            if (i == 0) rd(2'd0, 8'd0, "R3 index after first blue");
        end
        rd(2'd0, 8'd0, "R4 write index after 768 writes");
        pix_on = 1'b1;

        // R7: unmasked sweep of pixel lookups
        for (int i = 0; i < 256; i += 17) rd(2'd2, 8'(i), "R10 mask readback");

        // R1: reload halfway through a triple clears the counter
        wr(2'd0, 8'd250, 8'd250, "R1");
        wr(2'd1, 8'h3F, 8'd250, "R2");
        wr(2'd1, 8'h2A, 8'd250, "R2");
        wr(2'd0, 8'd10, 8'd250, "R1");
        rd(2'd0, 8'd10, "R1 write index reload");
        wr(2'd1, 8'h11, 8'd10, "R2 red");
        wr(2'd1, 8'h22, 8'd10, "R2 green, entry 10 still old");
        rd(2'd0, 8'd10, "R3 index held before blue");
        wr(2'd1, 8'hF3, 8'd10, "R8 blue with same-cycle lookup");
        rd(2'd0, 8'd10, "R3 index after blue");
        rd(2'd0, 8'd250, "R1 entry 250 untouched");

        // R4: write wrap 255 -> 0
        wr(2'd0, 8'd255, 8'd255, "R1");
        wr(2'd1, 8'h01, 8'd255, "R2");
        wr(2'd1, 8'h02, 8'd255, "R2");
        wr(2'd1, 8'h03, 8'd255, "R2");
        rd(2'd0, 8'd255, "R4 write wrap");

        // R5: read sequence with wrap
        wr(2'd3, 8'd254, 8'd0, "R5");
        for (int i = 0; i < 9; i++) rd(2'd1, 8'(i), "R5/R6 data readback");
        rd(2'd3, 8'd0, "R5 read index after wrap");
        // reload halfway through a read triple
        wr(2'd3, 8'd5, 8'd0, "R5");
        rd(2'd1, 8'd0, "R5 red");
        wr(2'd3, 8'd7, 8'd0, "R5 reload");
        for (int i = 0; i < 3; i++) rd(2'd1, 8'd7, "R5 entry 7");

        // R10: index reads have no side effects; write wins over read
        rd(2'd3, 8'd0, "R10");
        rd(2'd3, 8'd0, "R10 read index stable");
        step(2'd1, 1'b1, 1'b1, 8'h15, 8'd0, "R10 write priority");
        rd(2'd1, 8'd0, "R10 read counter not advanced");
        rd(2'd0, 8'd0, "R10 write side advanced");

        // R7: masks
        wr(2'd2, 8'h0F, 8'hF3, "R7");
        rd(2'd2, 8'hF3, "R7 mask readback");
        rd(2'd0, 8'hA5, "R7 masked lookup");
        wr(2'd2, 8'h00, 8'hFF, "R7");
        rd(2'd0, 8'h77, "R7 zero mask");
        wr(2'd2, 8'hFF, 8'h99, "R7");
        rd(2'd0, 8'h99, "R7 full mask");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule